// File: doc/BRIEF.md
# Calendar Clock Register Bank

This block sits at the top of a 32K-byte byte-wide address space and holds a calendar clock. The clock has seconds, minutes, hours, day of week, date, month and year. Every field is a BCD counter. A one-cycle pulse on `tick_1hz` advances the counters once. Host software reaches the clock through the same chip-enable, write-enable and output-enable port that serves the RAM below it. The port uses active-low enables and is sampled on the rising clock edge. Read data comes back one cycle after the read is sampled, together with a registered output-enable flag. The clock window is the eight byte addresses whose upper twelve address bits are all ones. Below that window, the RAM is a small stub addressed by the low address bits.

Each clock byte keeps a user-visible copy that holds every bit written to it. The counting field of that byte is refreshed from the live counters whenever neither hold bit is set. Bits that no counter uses act as plain storage. Control byte bit 7 is a write hold: it stops refreshes, and when it is cleared the counters load what was written. Control byte bit 6 is a read hold: it freezes the copy while the counters run on. Seconds byte bit 7 stops the counters. Day byte bit 6 is a frequency-test flag that is stored and read back. A power-fail input shuts out every access.

Top module: `cal_regbank`

## Requirements
- R1: After reset, the bytes read back as control 0x00, seconds 0x00, minutes 0x00, hours 0x00, day 0x01, date 0x01, month 0x01 and year 0x00.
- R2: The byte offsets inside the window are 0 control, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month and 7 year. Any address below the window reaches the RAM stub, indexed by its low address bits. A write there is returned by a later read.
- R3: Each tick raises seconds by one in BCD. Seconds 59 wraps to 00 and carries into minutes. Minutes 59 wraps to 00 and carries into hours. Hours 23 wraps to 00 and carries into both date and day of week.
- R4: Date wraps to 01 and carries into month after day 31 of months 01, 03, 05, 07, 08, 10 and 12. It does so after day 30 of months 04, 06, 09 and 11. In February it does so after day 29 when the year value is a multiple of 4, and after day 28 otherwise.
- R5: Day of week wraps from 07 to 01. Month wraps from 12 to 01 and carries into year. Year wraps from 99 to 00.
- R6: While seconds bit 7 is 1, ticks change no counter. That bit reads back as written.
- R7: Bits outside the counting fields read back as last written. These are control bits 5:0, minutes bit 7, hours bits 7:6, day bits 7:3 (bit 6 being the frequency-test flag), date bits 7:6 and month bits 7:5.
- R8: While control bit 7 is 1, ticks do not change the bytes read back. Writing control with bit 7 cleared loads all counters from the written bytes.
- R9: While control bit 7 is 0, writing a clock byte loads its counting field into the counter at once.
- R10: While control bit 6 is 1, the bytes read back stay frozen while counting goes on. After the bit is cleared, the bytes show the current count.
- R11: While `pwr_fail` is 1, writes change neither the clock nor the RAM, and reads do not assert `rdata_oe`.
- R12: `rdata_oe` is 1 exactly one cycle after an edge that sampled `ce_n`=0, `oe_n`=0, `we_n`=1 and `pwr_fail`=0. At all other times it is 0 and `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse that advances time by one second |
| pwr_fail | input | 1 | Blocks all reads and writes while high |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 15 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered, zero when not enabled |
| rdata_oe | output | 1 | High when `rdata` carries read data |

## Verification
The hardest states to reach from the ports are the carry chain's far corners: the leap-year February end, 30-day months and the year wrap. Each of these needs seven bytes preset exactly, and the preset can only be done under the write hold. The bench therefore loads each corner through the hold-and-release path and then issues a single tick. A second difficulty is telling the two holds apart. The live counters are hidden, so their progress under the read hold shows only after release. The bench counts ticks during the freeze and checks the jump once the read hold is cleared.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int NREG = 8;
  typedef logic [7:0] byte_t;
  typedef logic [NREG-1:0][7:0] bank_t;

  localparam int IX_CTRL = 0;
  localparam int IX_SEC  = 1;
  localparam int IX_MIN  = 2;
  localparam int IX_HR   = 3;
  localparam int IX_DOW  = 4;
  localparam int IX_DATE = 5;
  localparam int IX_MON  = 6;
  localparam int IX_YR   = 7;

  localparam int CTRL_WHOLD = 7;
  localparam int CTRL_RHOLD = 6;
  localparam int SEC_STOP   = 7;

  // counting field of each byte; index 7 is leftmost
  localparam bank_t FIELD_MASK = {8'hFF, 8'h1F, 8'h3F, 8'h07, 8'h3F, 8'h7F, 8'h7F, 8'h00};
  localparam bank_t RESET_BANK = {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00};
  localparam bank_t FIELD_LO   = {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00};

  function automatic byte_t month_last_day(input byte_t mon, input byte_t yr);
    logic [6:0] ybin;
    byte_t      last;
    ybin = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
    case (mon)
      8'h02:                      last = (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last = 8'h30;
      default:                    last = 8'h31;
    endcase
    return last;
  endfunction
endpackage

// File: rtl/cal_bcd_field.sv
module cal_bcd_field
  import cal_pkg::*;
(
  input  byte_t cur,
  input  byte_t lo,
  input  byte_t hi,
  input  logic  en,
  output byte_t nxt
);
  always_comb begin
    nxt = cur;
    if (en) begin
      if (cur >= hi) begin
        nxt = lo;
      end else if (cur[3:0] >= 4'd9) begin
        nxt[3:0] = 4'd0;
        nxt[7:4] = cur[7:4] + 4'd1;
      end else begin
        nxt[3:0] = cur[3:0] + 4'd1;
      end
    end
  end
endmodule

// File: rtl/cal_time_core.sv
module cal_time_core
  import cal_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            adv,
  input  logic [NREG-1:0] load_en,
  input  bank_t           load_val,
  output bank_t           cnt
);
  bank_t           cnt_q;
  bank_t           nxt;
  bank_t           hi_v;
  logic [NREG-1:0] at_hi;
  logic [NREG-1:0] en;

  always_comb begin
    hi_v = {8'h99, 8'h12, month_last_day(cnt_q[IX_MON], cnt_q[IX_YR]),
            8'h07, 8'h23, 8'h59, 8'h59, 8'h00};
    at_hi = '0;
    for (int i = 1; i < NREG; i++) at_hi[i] = (cnt_q[i] >= hi_v[i]);
    en           = '0;
    en[IX_SEC]   = adv;
    en[IX_MIN]   = en[IX_SEC]  & at_hi[IX_SEC];
    en[IX_HR]    = en[IX_MIN]  & at_hi[IX_MIN];
    en[IX_DOW]   = en[IX_HR]   & at_hi[IX_HR];
    en[IX_DATE]  = en[IX_HR]   & at_hi[IX_HR];
    en[IX_MON]   = en[IX_DATE] & at_hi[IX_DATE];
    en[IX_YR]    = en[IX_MON]  & at_hi[IX_MON];
  end

  assign nxt[0] = '0;

  for (genvar g = 1; g < NREG; g++) begin : g_field
    cal_bcd_field u_field (
      .cur (cnt_q[g]),
      .lo  (FIELD_LO[g]),
      .hi  (hi_v[g]),
      .en  (en[g]),
      .nxt (nxt[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= RESET_BANK;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (load_en[i]) cnt_q[i] <= load_val[i] & FIELD_MASK[i];
        else            cnt_q[i] <= nxt[i];
      end
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/cal_bus_decode.sv
module cal_bus_decode #(
  parameter int ADDR_W = 15,
  parameter int REG_AW = 3,
  parameter int RAM_AW = 6
) (
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              pwr_fail,
  input  logic [ADDR_W-1:0] addr,
  output logic              clk_hit,
  output logic              wr_en,
  output logic              oe_en,
  output logic [REG_AW-1:0] reg_ix,
  output logic [RAM_AW-1:0] ram_ix
);
  logic sel;
  assign sel     = !ce_n && !pwr_fail;
  assign clk_hit = &addr[ADDR_W-1:REG_AW];
  assign wr_en   = sel && !we_n;
  assign oe_en   = sel && we_n && !oe_n;
  assign reg_ix  = addr[REG_AW-1:0];
  assign ram_ix  = addr[RAM_AW-1:0];
endmodule

// File: rtl/cal_ram_stub.sv
module cal_ram_stub #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/cal_regbank.sv
module cal_regbank
  import cal_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int RAM_DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1hz,
  input  logic              pwr_fail,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              rdata_oe
);
  localparam int REG_AW = $clog2(NREG);
  localparam int RAM_AW = $clog2(RAM_DEPTH);

  logic              clk_hit, wr_en, oe_en;
  logic [REG_AW-1:0] reg_ix;
  logic [RAM_AW-1:0] ram_ix;
  logic              wr_clk, wr_ram;
  logic              whold, rhold, stop, w_release, load_any, adv;
  logic [NREG-1:0]   load_en;
  bank_t             load_val, cnt, vis_q;
  byte_t             ram_q, reg_rd_q;
  logic              rd_oe_q, sel_clk_q;

  cal_bus_decode #(.ADDR_W(ADDR_W), .REG_AW(REG_AW), .RAM_AW(RAM_AW)) u_dec (
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .pwr_fail(pwr_fail), .addr(addr),
    .clk_hit(clk_hit), .wr_en(wr_en), .oe_en(oe_en), .reg_ix(reg_ix), .ram_ix(ram_ix)
  );

  assign wr_clk = wr_en && clk_hit;
  assign wr_ram = wr_en && !clk_hit;

  assign whold = vis_q[IX_CTRL][CTRL_WHOLD];
  assign rhold = vis_q[IX_CTRL][CTRL_RHOLD];
  assign stop  = vis_q[IX_SEC][SEC_STOP];

  assign w_release = wr_clk && (reg_ix == REG_AW'(IX_CTRL)) && whold && !wdata[CTRL_WHOLD];

  always_comb begin
    load_en  = '0;
    load_val = {NREG{wdata}};
    if (w_release) begin
      load_en  = '1;
      load_val = vis_q;
    end else if (wr_clk && !whold) begin
      load_en[reg_ix] = 1'b1;
    end
  end

  assign load_any = |load_en;
  assign adv      = tick_1hz && !stop && !load_any;

  cal_time_core u_core (
    .clk(clk), .rst(rst), .adv(adv), .load_en(load_en), .load_val(load_val), .cnt(cnt)
  );

  // visible copy: full bytes, counting fields refreshed when no hold is set
  always_ff @(posedge clk) begin
    if (rst) begin
      vis_q <= RESET_BANK;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (wr_clk && reg_ix == REG_AW'(i))
          vis_q[i] <= wdata;
        else if (!whold && !rhold)
          vis_q[i] <= (vis_q[i] & ~FIELD_MASK[i]) | (cnt[i] & FIELD_MASK[i]);
      end
    end
  end

  cal_ram_stub #(.DEPTH(RAM_DEPTH), .DW(8)) u_ram (
    .clk(clk), .we(wr_ram), .addr(ram_ix), .wdata(wdata), .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_oe_q   <= 1'b0;
      sel_clk_q <= 1'b0;
      reg_rd_q  <= '0;
    end else begin
      rd_oe_q   <= oe_en;
      sel_clk_q <= clk_hit;
      reg_rd_q  <= vis_q[reg_ix];
    end
  end

  assign rdata    = rd_oe_q ? (sel_clk_q ? reg_rd_q : ram_q) : 8'h00;
  assign rdata_oe = rd_oe_q;
endmodule

// File: rtl/cal_regbank_chk.sv
module cal_regbank_chk
  import cal_pkg::*;
(
  input logic  clk,
  input logic  rst,
  input logic  ce_n,
  input logic  we_n,
  input logic  oe_n,
  input logic  pwr_fail,
  input logic  rdata_oe,
  input logic  adv,
  input logic  stop,
  input logic  whold,
  input logic  rhold,
  input logic  wr_any,
  input logic  load_any,
  input bank_t cnt_bank,
  input bank_t vis_bank
);
  AST_OE_QUAL: assert property (@(posedge clk) disable iff (rst)
    rdata_oe |-> $past(!ce_n && !oe_n && we_n && !pwr_fail)); // R12

  AST_PF_BLOCK: assert property (@(posedge clk) disable iff (rst)
    pwr_fail |=> !rdata_oe); // R11

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (adv && cnt_bank[IX_SEC] == 8'h59) |=> (cnt_bank[IX_SEC] == 8'h00)); // R3

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (stop && !load_any) |=> $stable(cnt_bank)); // R6

  AST_WHOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (whold && !wr_any) |=> $stable(vis_bank)); // R8

  AST_RHOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (rhold && !wr_any) |=> $stable(vis_bank)); // R10
endmodule

bind cal_regbank cal_regbank_chk u_chk (
  .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .pwr_fail(pwr_fail),
  .rdata_oe(rdata_oe), .adv(adv), .stop(stop), .whold(whold), .rhold(rhold),
  .wr_any(wr_clk), .load_any(load_any), .cnt_bank(cnt), .vis_bank(vis_q)
);

// File: tb/cal_regbank_bench.sv
`timescale 1ns/1ps
module cal_regbank_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_1hz = 1'b0, pwr_fail = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rdata_oe;

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  localparam logic [14:0] A_CTRL = 15'h7FF8, A_SEC = 15'h7FF9, A_MIN = 15'h7FFA,
                          A_HR = 15'h7FFB, A_DOW = 15'h7FFC, A_DATE = 15'h7FFD,
                          A_MON = 15'h7FFE, A_YR = 15'h7FFF;

  always #10 clk = ~clk;

  cal_regbank u_cal_regbank (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .pwr_fail(pwr_fail),
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  // monitor: pops expected items as read data appears
  always @(negedge clk) begin
    if (!rst && rdata_oe) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R12 unexpected output", rdata, 8'h00);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string      t = tag_q.pop_front();
        check(rdata == e, t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic rd(input logic [14:0] a, input logic [7:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = a;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic rd_silent(input logic [14:0] a, input logic oe_val, input string tag);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b1; oe_n = oe_val; addr = a;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
    check(rdata_oe == 1'b0, tag, {7'd0, rdata_oe}, 8'h00);
    check(rdata == 8'h00, tag, rdata, 8'h00);
  endtask

  task automatic tick();
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                          input logic [7:0] dt, input logic [7:0] mo, input logic [7:0] y);
    wr(A_CTRL, 8'h80);
    wr(A_SEC, s); wr(A_MIN, m); wr(A_HR, h);
    wr(A_DATE, dt); wr(A_MON, mo); wr(A_YR, y);
    wr(A_CTRL, 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    rd(A_CTRL, 8'h00, "R1 ctrl"); rd(A_SEC, 8'h00, "R1 sec");
    rd(A_DOW, 8'h01, "R1 day");   rd(A_DATE, 8'h01, "R1 date");
    rd(A_MON, 8'h01, "R1 month"); rd(A_YR, 8'h00, "R1 year");

    // R2 RAM stub
    wr(15'h0005, 8'hA5); wr(15'h7FF7, 8'h3C);
    rd(15'h0005, 8'hA5, "R2 ram low"); rd(15'h7FF7, 8'h3C, "R2 ram top");

    // R7 spare bits, R9 direct load
    wr(A_CTRL, 8'h15); rd(A_CTRL, 8'h15, "R7 ctrl spare");
    wr(A_MIN, 8'h80);  rd(A_MIN, 8'h80, "R7 min spare");
    wr(A_HR, 8'hC0);   rd(A_HR, 8'hC0, "R7 hour spare");
    wr(A_CTRL, 8'h00);

    // R8 write hold
    wr(A_CTRL, 8'h80);
    wr(A_SEC, 8'h58); wr(A_MIN, 8'h59); wr(A_HR, 8'h23); wr(A_DOW, 8'h47);
    wr(A_DATE, 8'h28); wr(A_MON, 8'h02); wr(A_YR, 8'h23);
    rd(A_DOW, 8'h47, "R7 day test flag");
    tick(); tick();
    rd(A_SEC, 8'h58, "R8 frozen under write hold");
    wr(A_CTRL, 8'h00);
    tick();
    rd(A_SEC, 8'h59, "R8 load on release / R3 count");
    tick();
    rd(A_SEC, 8'h00, "R3 sec wrap"); rd(A_MIN, 8'h00, "R3 min wrap");
    rd(A_HR, 8'h00, "R3 hour wrap"); rd(A_DOW, 8'h41, "R5 day 07->01");
    rd(A_DATE, 8'h01, "R4 feb 28 non-leap"); rd(A_MON, 8'h03, "R4 month carry");
    rd(A_YR, 8'h23, "R3 year held");

    // R4 leap and month lengths
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24); tick();
    rd(A_DATE, 8'h29, "R4 leap feb 29"); rd(A_MON, 8'h02, "R4 leap month");
    set_time(8'h59, 8'h59, 8'h23, 8'h29, 8'h02, 8'h24); tick();
    rd(A_DATE, 8'h01, "R4 leap feb end"); rd(A_MON, 8'h03, "R4 leap march");
    set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h24); tick();
    rd(A_DATE, 8'h01, "R4 30-day month"); rd(A_MON, 8'h05, "R4 april end");
    set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h05, 8'h24); tick();
    rd(A_DATE, 8'h31, "R4 31-day month");

    // R5 year wrap
    set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99); tick();
    rd(A_DATE, 8'h01, "R5 date"); rd(A_MON, 8'h01, "R5 month wrap");
    rd(A_YR, 8'h00, "R5 year wrap");

    // R6 stop bit
    set_time(8'h90, 8'h00, 8'h10, 8'h05, 8'h06, 8'h24);
    tick(); tick(); tick();
    rd(A_SEC, 8'h90, "R6 stopped");
    wr(A_SEC, 8'h10);
    tick();
    rd(A_SEC, 8'h11, "R9 direct load then R6 run");

    // R10 read hold
    wr(A_CTRL, 8'h40);
    tick(); tick();
    rd(A_SEC, 8'h11, "R10 snapshot frozen");
    wr(A_CTRL, 8'h00);
    repeat (2) @(negedge clk);
    rd(A_SEC, 8'h13, "R10 refresh after release");

    // R11 power fail
    @(negedge clk); pwr_fail = 1'b1;
    wr(15'h0005, 8'h11); wr(A_MIN, 8'h33);
    rd_silent(15'h0005, 1'b0, "R11 read blocked");
    @(negedge clk); pwr_fail = 1'b0;
    rd(15'h0005, 8'hA5, "R11 ram unchanged");
    rd(A_MIN, 8'h00, "R11 clock unchanged");

    // R12 output enable gating
    rd_silent(A_SEC, 1'b1, "R12 oe_n high");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R12 missing outputs", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    summary();
  end
endmodule